// File: doc/BRIEF.md
# Receive Descriptor Ring Fetcher

This block supplies free receive buffers to an Ethernet receive datapath. A host keeps a circular queue of two-word descriptors in one contiguous memory region. Three settings define the queue: a base address, a queue length in bytes, and a current address that points at the next descriptor to read. The host hands descriptors to the block by writing a count of newly added entries. The block keeps a running count of descriptors that it has not yet fetched.

While the block is enabled and that count is nonzero, it reads one descriptor through a word-wide request/response memory port. It then offers the buffer to the datapath through a valid/ready handshake. The offer carries the buffer address, the maximum byte count, a host-chosen index and a not-start-of-frame flag. The next fetch starts only after the datapath accepts the offer. A descriptor with a zero length is consumed without being offered. The current pointer wraps by masking its offset from the base, so the queue must hold a power-of-two number of descriptors.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset there is no memory request and no offer, the available count is zero, the base and current pointers hold the reset base, and the length holds the reset length. The first fetch reads from the reset base.
- R2: A descriptor is read as two single-word reads: word 0 at the current pointer, then word 1 at the current pointer plus 4. Only one read is outstanding at a time. The request and its address stay steady until the response arrives.
- R3: The offered buffer address is word 0 with bits [1:0] forced to zero. Word 1 supplies the other fields: bits [15:0] give the length in bytes, bits [30:16] give the index, and bit 31 gives the not-start-of-frame flag.
- R4: An offer and all of its fields stay steady until the datapath asserts ready. No memory request is made while an offer is pending.
- R5: A descriptor whose length field is zero is never offered. It still counts as consumed, and the pointer still advances past it.
- R6: After each descriptor the pointer becomes base + ((current − base + 8) AND (length − 1)). Every read address lies in [base, base + length). A descriptor fetched from the last slot is followed by a fetch at the base.
- R7: A configuration write with select 3 adds the low CW bits of the data to the available count. Each fetched descriptor removes one from the count, and both can happen in the same cycle. A fetch starts only while enable is high and the count is nonzero.
- R8: Select 0 writes the base, select 1 writes the length and select 2 writes the current pointer, with the low two address bits cleared. These writes take effect only while enable is low and no fetch or offer is in progress; otherwise they are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new descriptor fetches |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 base, 1 length, 2 current, 3 enqueue count |
| cfg_wdata | input | AW | Configuration write data |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid (completes request) |
| mem_rdata | input | 32 | Read response data |
| buf_valid | output | 1 | Buffer offer valid |
| buf_ready | input | 1 | Datapath accepts the offer |
| buf_addr | output | AW | Word-aligned buffer address |
| buf_len | output | LW | Maximum byte count of the buffer |
| buf_index | output | 31-LW | Host index of the buffer |
| buf_nsof | output | 1 | Not-start-of-frame flag |
| avail_cnt | output | CW | Descriptors enqueued but not yet fetched |

## Verification
The bench uses the default parameters: a 32-bit address, a 16-bit count, a 16-bit length field, a reset base of 0 and a reset length of 8 bytes. With these values the block starts with a one-entry ring, so every descriptor wraps straight back to the base. Other runs program rings of two to sixteen entries at unaligned-to-ring bases with a start point partway through, which reaches wrap from the last slot and runs of zero-length entries. Random memory latency and random ready make enqueue and decrement coincide and stretch offers over many cycles.

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 16,
  parameter logic [AW-1:0] RST_BASE = '0,
  parameter logic [AW-1:0] RST_LEN = AW'(8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          buf_valid,
  input  logic          buf_ready,
  output logic [AW-1:0] buf_addr,
  output logic [LW-1:0] buf_len,
  output logic [30-LW:0] buf_index,
  output logic          buf_nsof,
  output logic [CW-1:0] avail_cnt
);
  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1, S_OFFER} st_t;

  st_t            st;
  logic [AW-1:0]  base_q, len_q, cur_q;
  logic [CW-1:0]  avail_q;
  logic [AW-1:2]  word0_q;
  logic [31:0]    word1_q;

  wire cfg_ok  = cfg_we && !enable && st == S_IDLE;
  wire wr_base = cfg_ok && cfg_sel == 2'd0;
  wire wr_len  = cfg_ok && cfg_sel == 2'd1;
  wire wr_cur  = cfg_ok && cfg_sel == 2'd2;
  wire enq     = cfg_we && cfg_sel == 2'd3;
  wire start   = st == S_IDLE && enable && avail_q != '0;
  wire got_w0  = st == S_W0 && mem_rvalid;
  wire done    = st == S_W1 && mem_rvalid;

  wire [AW-1:0] off_next = (cur_q - base_q + AW'(8)) & (len_q - AW'(1));
  wire [AW-1:0] cur_next = base_q + off_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= {RST_BASE[AW-1:2], 2'b00};
      cur_q   <= {RST_BASE[AW-1:2], 2'b00};
      len_q   <= RST_LEN;
      avail_q <= '0;
      word0_q <= '0;
      word1_q <= '0;
    end else begin
      if (wr_base) base_q <= {cfg_wdata[AW-1:2], 2'b00};
      if (wr_len)  len_q  <= cfg_wdata;
      if (done)        cur_q <= cur_next;
      else if (wr_cur) cur_q <= {cfg_wdata[AW-1:2], 2'b00};
      avail_q <= avail_q + (enq ? cfg_wdata[CW-1:0] : '0) - CW'(done);
      if (got_w0) word0_q <= mem_rdata[AW-1:2];
      if (done)   word1_q <= mem_rdata;
      case (st)
        S_IDLE:  if (start) st <= S_W0;
        S_W0:    if (mem_rvalid) st <= S_W1;
        S_W1:    if (mem_rvalid) st <= (mem_rdata[LW-1:0] == '0) ? S_IDLE : S_OFFER;
        S_OFFER: if (buf_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = st == S_W0 || st == S_W1;
  assign mem_addr  = (st == S_W1) ? cur_q + AW'(4) : cur_q;
  assign buf_valid = st == S_OFFER;
  assign buf_addr  = {word0_q, 2'b00};
  assign buf_len   = word1_q[LW-1:0];
  assign buf_index = word1_q[30:LW];
  assign buf_nsof  = word1_q[31];
  assign avail_cnt = avail_q;
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          buf_valid,
  input logic          buf_ready,
  input logic [AW-1:0] buf_addr,
  input logic [LW-1:0] buf_len,
  input logic [30-LW:0] buf_index,
  input logic          buf_nsof,
  input logic [CW-1:0] avail_cnt,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] len_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R2
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> buf_addr[1:0] == 2'b00); // R3
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len)
      && $stable(buf_index) && $stable(buf_nsof)); // R4
  AST_NO_REQ_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !mem_req); // R4
  AST_NO_ZERO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> buf_len != '0); // R5
  AST_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr - base_q) < len_q); // R6
  AST_NO_FETCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(enable) && $past(avail_cnt) != '0); // R7
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.AW(AW), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .buf_valid(buf_valid), .buf_ready(buf_ready),
  .buf_addr(buf_addr), .buf_len(buf_len), .buf_index(buf_index), .buf_nsof(buf_nsof),
  .avail_cnt(avail_cnt), .base_q(base_q), .len_q(len_q)
);

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
  logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic mem_req, mem_rvalid = 0, buf_valid, buf_ready = 0, buf_nsof;
  logic [31:0] mem_addr, mem_rdata = '0, buf_addr;
  logic [15:0] buf_len, avail_cnt;
  logic [14:0] buf_index;

  always #2 clk = ~clk;

  rx_desc_ring i_rx_desc_ring (.*);

  int n_cmp = 0, n_err = 0, cyc = 0, offers = 0, lat = 0;
  bit hold = 0, rd_odd = 0;
  logic [31:0] mem [0:511];
  logic [31:0] m_base = 0, m_len = 8, m_ptr = 0, last_a0 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  function automatic logic [31:0] wrap(input logic [31:0] p);
    return m_base + ((p - m_base + 32'd8) & (m_len - 32'd1));
  endfunction

  function automatic int count_nz(input logic [31:0] p, input int n);
    int c = 0;
    for (int k = 0; k < n; k++) begin
      if (mem[(p + 32'd4) >> 2][15:0] != 16'd0) c++;
      p = wrap(p);
    end
    return c;
  endfunction

  task automatic model_next(output logic [31:0] a, output logic [31:0] w1);
    for (int k = 0; k < 64; k++) begin
      a  = mem[m_ptr >> 2] & 32'hFFFF_FFFC;
      w1 = mem[(m_ptr + 32'd4) >> 2];
      m_ptr = wrap(m_ptr);
      if (w1[15:0] != 16'd0) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 0;
    else if (mem_req) begin
      if (lat == 0) begin
        chk(mem_addr - m_base < m_len, "R6 read in ring", mem_addr, m_base);
        if (rd_odd) chk(mem_addr == last_a0 + 32'd4, "R2 word1 addr", mem_addr, last_a0 + 32'd4);
        else last_a0 = mem_addr;
        rd_odd = !rd_odd;
        mem_rdata = mem[mem_addr[10:2]];
        mem_rvalid = 1;
        lat = $urandom % 3;
      end else lat--;
    end
  end

  always @(negedge clk) begin
    logic [31:0] ea, ew;
    buf_ready = hold ? 1'b0 : (($urandom % 4) != 0);
    if (buf_valid && buf_ready) begin
      model_next(ea, ew);
      offers++;
      chk(buf_addr == ea, "R3 addr", buf_addr, ea);
      chk(buf_len == ew[15:0], "R3 len", {16'd0, buf_len}, {16'd0, ew[15:0]});
      chk(buf_index == ew[30:16], "R3 index", {17'd0, buf_index}, {17'd0, ew[30:16]});
      chk(buf_nsof == ew[31], "R3 nsof", {31'd0, buf_nsof}, {31'd0, ew[31]});
    end
  end

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_en(input bit e);
    @(negedge clk); enable = e;
  endtask

  task automatic drain(input int exp_offers, input string tag);
    int quiet = 0;
    for (int k = 0; k < 4000 && quiet < 6; k++) begin
      @(negedge clk);
      if (avail_cnt == 0 && !buf_valid && !mem_req) quiet++; else quiet = 0;
    end
    chk(offers == exp_offers, tag, offers, exp_offers);
    chk(avail_cnt == 0, "R7 count drained", {16'd0, avail_cnt}, 0);
  endtask

  task automatic fill(input logic [31:0] b, input int n);
    for (int k = 0; k < n; k++) begin
      mem[(b >> 2) + 2 * k] = $urandom;
      mem[(b >> 2) + 2 * k + 1] = {$urandom} & 32'hFFFF_0000
        | ((($urandom % 4) == 0) ? 32'd0 : ((($urandom % 64) + 1) * 4));
    end
    mem[(b >> 2) + 1][15:0] = 16'd64;
  endtask

  task automatic phase(input logic [31:0] b, input logic [31:0] l, input logic [31:0] c,
                       input int n, input bit poke, input string tag);
    int left = n, exp_n;
    set_en(0);
    cfg(2'd0, b); cfg(2'd1, l); cfg(2'd2, c);
    m_base = b; m_len = l; m_ptr = c; offers = 0;
    exp_n = count_nz(c, n);
    set_en(1);
    if (poke) begin
      cfg(2'd0, 32'h300); cfg(2'd1, 32'h10); cfg(2'd2, 32'h308);
    end
    while (left > 0) begin
      int k = 1 + $urandom % 4;
      if (k > left) k = left;
      cfg(2'd3, k);
      left -= k;
      repeat ($urandom % 6) @(negedge clk);
    end
    drain(exp_n, tag);
  endtask

  initial begin
    logic [31:0] ha, hl;
    void'($urandom(32'd2024));
    for (int k = 0; k < 512; k++) mem[k] = '0;
    mem[0] = 32'h0000_1003;
    mem[1] = {1'b1, 15'h1234, 16'h0040};
    repeat (3) @(negedge clk);
    chk(!mem_req, "R1 no request", {31'd0, mem_req}, 0);
    chk(!buf_valid, "R1 no offer", {31'd0, buf_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(avail_cnt == 0, "R1 count zero", {16'd0, avail_cnt}, 0);
    enable = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k % 5 == 0) chk(!mem_req, "R7 no fetch when empty", {31'd0, mem_req}, 0);
    end
    set_en(0);
    cfg(2'd3, 32'd2);
    repeat (20) @(negedge clk);
    chk(!mem_req, "R7 no fetch when disabled", {31'd0, mem_req}, 0);
    chk(avail_cnt == 2, "R7 enqueue adds", {16'd0, avail_cnt}, 2);
    set_en(1);
    drain(2, "R1 reset ring offers");

    phase(32'h100, 32'h80, 32'h100, 40, 1, "R8 writes ignored offers");
    fill(32'h404, 4);
    phase(32'h404, 32'h20, 32'h414, 11, 0, "R6 wrap offers");

    for (int k = 0; k < 8; k++) begin
      mem[(32'h200 >> 2) + 2 * k] = 32'h4000 + k * 32'h100;
      mem[(32'h200 >> 2) + 2 * k + 1] = 32'h0003_0000;
    end
    mem[(32'h200 >> 2) + 15] = 32'h0007_0020;
    phase(32'h200, 32'h40, 32'h200, 8, 0, "R5 zero skipped offers");

    set_en(0);
    fill(32'h600, 2);
    cfg(2'd0, 32'h600); cfg(2'd1, 32'h10); cfg(2'd2, 32'h600);
    m_base = 32'h600; m_len = 32'h10; m_ptr = 32'h600; offers = 0;
    @(posedge clk); hold = 1;
    set_en(1);
    cfg(2'd3, 32'd1);
    for (int k = 0; k < 100 && !buf_valid; k++) @(negedge clk);
    ha = buf_addr; hl = {16'd0, buf_len};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(buf_valid && buf_addr == ha && buf_len == hl[15:0], "R4 offer held", buf_addr, ha);
      chk(!mem_req, "R4 no request during offer", {31'd0, mem_req}, 0);
    end
    @(posedge clk); hold = 0;
    drain(1, "R4 held offer taken");

    for (int r = 0; r < 4; r++) begin
      int nd = 2 << ($urandom % 4);
      logic [31:0] b = 32'h700 + 32'd4 * ($urandom % 8);
      fill(b, nd);
      phase(b, nd * 8, b + 8 * ($urandom % nd), 10 + $urandom % 30, 0, "R6 random ring offers");
    end

    summary();
    $finish;
  end
endmodule